// File: doc/BRIEF.md
# Sound-Feed Channel Pause Timer

This block times the PAUSE instruction of a sound-feeding DMA engine with three channels. Each channel holds a prescale value N that software writes. The channel's divider turns the scan-line strobe into one tick every N+1 lines. A PAUSE loads a count M. Each tick lowers the count by one, and while the count is nonzero the channel reports itself paused. The instruction sequencer treats a paused channel as inactive, so it neither fetches nor executes that channel's next instruction until the count reaches zero.

Channel enable does not touch the timer. A pause keeps counting while its channel is disabled or while the sequencer moves the channel's address. A later re-enable therefore still waits for the count to drain. A prescale write clears that channel's divider phase and applies the new N at once, in the middle of a pause. Loading a pause also clears the divider phase. The first tick therefore lands exactly N+1 lines after the load.

Top module: `sfd_pause_timer`

## Requirements
- R1: After reset every pause count, prescale value and divider phase is zero, so `paused` is all zeros and `fetch_ok` equals `chan_en`.
- R2: A clock with `pause_ld[c]` high loads `pause_val` into channel c. If the value is nonzero, `paused[c]` is 1 from the next cycle. If the value is 0, `paused[c]` is 0 from the next cycle, and any running pause ends.
- R3: With prescale N held, a pause of M clears on the M×(N+1)-th `line_stb` pulse after the load. `paused[c]` is 0 in the cycle after that pulse is sampled.
- R4: A clock with `psc_we` high and `psc_sel` equal to c stores `psc_val` as channel c's N, clears channel c's divider phase, and applies the new N to the ticks that remain. Example: N=0, PAUSE 10, five lines, then a write of N=1 gives 15 lines in total.
- R5: A pause load clears that channel's divider phase. The first decrement comes on the (N+1)-th strobe after the load.
- R6: `chan_en` has no effect on counting. `fetch_ok[c]` is `chan_en[c]` AND NOT `paused[c]`.
- R7: The channels are independent. A load or a prescale write to one channel leaves the count and timing of the others unchanged.
- R8: In a cycle where a channel is loaded or its prescale is written, a `line_stb` pulse is not counted for that channel. The loaded value wins over any decrement.
- R9: A count at zero stays at zero under strobes. It never wraps.
- R10: A prescale write with `psc_sel` at 3 or above changes no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per scan line |
| psc_we | input | 1 | Prescale write strobe |
| psc_sel | input | 2 | Channel index for the prescale write |
| psc_val | input | 8 | Prescale value N |
| pause_ld | input | 3 | Per-channel pause load strobe |
| pause_val | input | 12 | Pause count M |
| chan_en | input | 3 | Channel enable from the sequencer |
| paused | output | 3 | Channel pause count is nonzero |
| fetch_ok | output | 3 | Channel enabled and not paused |

## Verification
The assertions assume that `line_stb` is a pulse taken from the scan-line timing, and that loads and prescale writes come as single-cycle strobes. They place no rule on when these may meet. The stimulus follows that pattern: strobes one or two cycles apart, pulsed writes and loads, and some of them deliberately on the same clock as a strobe to test the priority rules. A lockstep behavioural model checks every cycle. Measured pause lengths are also compared against M×(N+1), including a prescale change in the middle of a pause and a write to an unused channel index.

// File: rtl/sfd_pause_pkg.sv
package sfd_pause_pkg;
  localparam int PSC_W = 8;
  localparam int CNT_W = 12;

  typedef logic [PSC_W-1:0] psc_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // divider has completed N+1 lines when this strobe arrives
  function automatic logic phase_done(input psc_t phase, input psc_t lim);
    return phase >= lim;
  endfunction

  // next divider phase; a clear forces zero and hides the strobe
  function automatic psc_t phase_next(input psc_t phase, input psc_t lim,
                                      input logic stb, input logic clr);
    psc_t r;
    if (clr)                        r = '0;
    else if (!stb)                  r = phase;
    else if (phase_done(phase, lim)) r = '0;
    else                            r = phase + psc_t'(1);
    return r;
  endfunction

  // next pause count; load wins, decrement saturates at zero
  function automatic cnt_t count_next(input cnt_t cnt, input logic ld,
                                      input cnt_t val, input logic tick);
    cnt_t r;
    if (ld)                     r = val;
    else if (tick && cnt != '0) r = cnt - cnt_t'(1);
    else                        r = cnt;
    return r;
  endfunction
endpackage

// File: rtl/sfd_psc_bank.sv
module sfd_psc_bank
  import sfd_pause_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SEL_W-1:0]      sel,
  input  psc_t                  val,
  output logic [NCH-1:0][PSC_W-1:0] n_q,
  output logic [NCH-1:0]        hit
);
  for (genvar c = 0; c < NCH; c++) begin : g_reg
    assign hit[c] = we && (sel == SEL_W'(c));
    always_ff @(posedge clk) begin
      if (!rst_n)      n_q[c] <= '0;
      else if (hit[c]) n_q[c] <= val;
    end
  end
endmodule

// File: rtl/sfd_line_divider.sv
module sfd_line_divider
  import sfd_pause_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic clr,
  input  psc_t lim,
  output psc_t phase_q,
  output logic tick
);
  assign tick = stb && !clr && phase_done(phase_q, lim);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_next(phase_q, lim, stb, clr);
  end
endmodule

// File: rtl/sfd_pause_counter.sv
module sfd_pause_counter
  import sfd_pause_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  cnt_t ld_val,
  input  logic tick,
  output cnt_t cnt_q,
  output logic busy
);
  assign busy = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= count_next(cnt_q, ld, ld_val, tick);
  end
endmodule

// File: rtl/sfd_pause_timer.sv
module sfd_pause_timer
  import sfd_pause_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_stb,
  input  logic             psc_we,
  input  logic [SEL_W-1:0] psc_sel,
  input  logic [PSC_W-1:0] psc_val,
  input  logic [NCH-1:0]   pause_ld,
  input  logic [CNT_W-1:0] pause_val,
  input  logic [NCH-1:0]   chan_en,
  output logic [NCH-1:0]   paused,
  output logic [NCH-1:0]   fetch_ok
);
  // named internal events, visible to the bound checker
  logic [NCH-1:0][PSC_W-1:0] psc_q;
  logic [NCH-1:0]            wr_hit;
  logic [NCH-1:0]            phase_clr;
  logic [NCH-1:0][PSC_W-1:0] phase_q;
  logic [NCH-1:0]            tick_w;
  logic [NCH-1:0][CNT_W-1:0] cnt_q;

  sfd_psc_bank #(.NCH(NCH), .SEL_W(SEL_W)) psc_i (
    .clk(clk), .rst_n(rst_n), .we(psc_we), .sel(psc_sel), .val(psc_val),
    .n_q(psc_q), .hit(wr_hit)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign phase_clr[c] = wr_hit[c] || pause_ld[c];

    sfd_line_divider div_i (
      .clk(clk), .rst_n(rst_n), .stb(line_stb), .clr(phase_clr[c]),
      .lim(psc_q[c]), .phase_q(phase_q[c]), .tick(tick_w[c])
    );

    sfd_pause_counter cnt_i (
      .clk(clk), .rst_n(rst_n), .ld(pause_ld[c]), .ld_val(pause_val),
      .tick(tick_w[c]), .cnt_q(cnt_q[c]), .busy(paused[c])
    );

    assign fetch_ok[c] = chan_en[c] && !paused[c];
  end
endmodule

// File: rtl/sfd_pause_timer_chk.sv
module sfd_pause_timer_chk
  import sfd_pause_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int SEL_W = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      line_stb,
  input logic [NCH-1:0]            pause_ld,
  input logic [CNT_W-1:0]          pause_val,
  input logic [NCH-1:0]            wr_hit,
  input logic [NCH-1:0][PSC_W-1:0] psc_q,
  input logic [NCH-1:0][PSC_W-1:0] phase_q,
  input logic [NCH-1:0]            tick_w,
  input logic [NCH-1:0][CNT_W-1:0] cnt_q,
  input logic [NCH-1:0]            paused
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_ld[c] && pause_val != '0) |=> paused[c]);
    a_r2_zero_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_ld[c] && pause_val == '0) |=> !paused[c]);
    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_w[c] && !pause_ld[c] && cnt_q[c] != '0)
        |=> cnt_q[c] == $past(cnt_q[c]) - CNT_W'(1));
    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_w[c] && !pause_ld[c]) |=> $stable(cnt_q[c]));
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[c] == '0 && !pause_ld[c]) |=> cnt_q[c] == '0);
    a_r5_load_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
      pause_ld[c] |=> phase_q[c] == '0);
    a_r4_write_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[c] |=> phase_q[c] == '0);
    a_r4_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q[c] <= psc_q[c]);
    a_r8_tick_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      tick_w[c] |-> (line_stb && !wr_hit[c] && !pause_ld[c]));
  end
endmodule

bind sfd_pause_timer sfd_pause_timer_chk #(.NCH(NCH), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .pause_ld(pause_ld),
  .pause_val(pause_val), .wr_hit(wr_hit), .psc_q(psc_q), .phase_q(phase_q),
  .tick_w(tick_w), .cnt_q(cnt_q), .paused(paused)
);

// File: tb/sfd_pause_timer_tb_top.sv
`timescale 1ns/1ps
module sfd_pause_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_stb = 1'b0;
  logic        psc_we = 1'b0;
  logic [1:0]  psc_sel = '0;
  logic [7:0]  psc_val = '0;
  logic [2:0]  pause_ld = '0;
  logic [11:0] pause_val = '0;
  logic [2:0]  chan_en = '0;
  logic [2:0]  paused;
  logic [2:0]  fetch_ok;

  int nchk = 0;
  int nerr = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt[3];
  int m_n[3];
  int m_ph[3];

  always #2.5 clk = ~clk;

  sfd_pause_timer dut_i (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .psc_we(psc_we),
    .psc_sel(psc_sel), .psc_val(psc_val), .pause_ld(pause_ld),
    .pause_val(pause_val), .chan_en(chan_en), .paused(paused),
    .fetch_ok(fetch_ok)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_update();
    for (int c = 0; c < 3; c++) begin
      bit wr = psc_we && (int'(psc_sel) == c);
      if (!rst_n) begin
        m_cnt[c] = 0; m_n[c] = 0; m_ph[c] = 0;
      end else if (wr || pause_ld[c]) begin
        if (wr) m_n[c] = int'(psc_val);
        if (pause_ld[c]) m_cnt[c] = int'(pause_val);
        m_ph[c] = 0;
      end else if (line_stb) begin
        if (m_ph[c] == m_n[c]) begin
          m_ph[c] = 0;
          if (m_cnt[c] > 0) m_cnt[c] = m_cnt[c] - 1;
        end else begin
          m_ph[c] = m_ph[c] + 1;
        end
      end
    end
  endtask

  task automatic compare();
    for (int c = 0; c < 3; c++) begin
      bit ep = (m_cnt[c] != 0);
      check(paused[c] == ep, cur_req, $sformatf("paused[%0d]", c), paused[c], ep);
      check(fetch_ok[c] == (chan_en[c] && !ep), "R6",
            $sformatf("fetch_ok[%0d]", c), fetch_ok[c], chan_en[c] && !ep);
    end
  endtask

  task automatic step(input logic s);
    line_stb = s;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    line_stb = 1'b0; psc_we = 1'b0; pause_ld = '0;
  endtask

  task automatic set_psc(input int c, input int n);
    psc_we = 1'b1; psc_sel = 2'(c); psc_val = 8'(n);
    step(1'b0);
  endtask

  task automatic load(input int c, input int m);
    pause_ld = 3'(1 << c); pause_val = 12'(m);
    step(1'b0);
  endtask

  // strobes every other cycle until channel c clears; returns lines counted
  task automatic measure(input int c, input int start, output int lines);
    lines = start;
    for (int k = 0; k < 60000; k++) begin
      step(1'b1);
      lines++;
      if (!paused[c]) break;
      step(1'b0);
    end
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int lines;
    bit [15:0] lfsr;
    @(negedge clk);
    step(1'b0); step(1'b1);
    rst_n = 1'b1;
    chan_en = 3'b111;
    step(1'b0);
    // R1: reset state
    check(paused == 3'b000, "R1", "paused after reset", paused, 0);
    check(fetch_ok == 3'b111, "R1", "fetch_ok after reset", fetch_ok, 7);

    // R2: zero load gives no pause; nonzero load pauses next cycle
    cur_req = "R2";
    load(0, 0);
    check(paused[0] == 1'b0, "R2", "zero load", paused[0], 0);
    load(0, 4);
    check(paused[0] == 1'b1, "R2", "nonzero load", paused[0], 1);
    load(0, 0);
    check(paused[0] == 1'b0, "R2", "zero load ends pause", paused[0], 0);

    // R3/R5: N=2, M=3 -> 9 lines, with a stray strobe beforehand
    cur_req = "R3";
    set_psc(0, 2);
    step(1'b1);
    load(0, 3);
    measure(0, 0, lines);
    check(lines == 9, "R3", "N=2 M=3 length", lines, 9);

    // R4: mid-pause prescale change, 5 at N=0 then N=1 -> 15
    cur_req = "R4";
    set_psc(1, 0);
    load(1, 10);
    for (int k = 0; k < 5; k++) begin step(1'b1); step(1'b0); end
    check(paused[1] == 1'b1, "R4", "still paused after 5", paused[1], 1);
    set_psc(1, 1);
    measure(1, 5, lines);
    check(lines == 15, "R4", "mid-pause prescale total", lines, 15);

    // R6: enable toggled mid-pause does not disturb the count
    cur_req = "R6";
    set_psc(2, 3);
    load(2, 2);
    chan_en[2] = 1'b0;
    for (int k = 0; k < 3; k++) begin step(1'b1); step(1'b0); end
    chan_en[2] = 1'b1;
    step(1'b0);
    check(fetch_ok[2] == 1'b0, "R6", "re-enabled while paused", fetch_ok[2], 0);
    measure(2, 3, lines);
    check(lines == 8, "R6", "length with enable toggled", lines, 8);

    // R7: concurrent channels with different settings
    cur_req = "R7";
    set_psc(0, 1); set_psc(1, 0); set_psc(2, 2);
    pause_ld = 3'b111; pause_val = 12'd3;
    step(1'b0);
    for (int k = 0; k < 20; k++) begin
      step(1'b1);
      if (k == 4) load(1, 2);
    end
    check(paused == 3'b000, "R7", "all drained", paused, 0);

    // R8: load and prescale write on a strobe cycle
    cur_req = "R8";
    set_psc(0, 0);
    pause_ld = 3'b001; pause_val = 12'd2;
    step(1'b1);
    check(paused[0] == 1'b1, "R8", "load beats strobe", paused[0], 1);
    psc_we = 1'b1; psc_sel = 2'd0; psc_val = 8'd0;
    step(1'b1);
    check(paused[0] == 1'b1, "R8", "write hides strobe", paused[0], 1);
    measure(0, 0, lines);
    check(lines == 2, "R8", "remaining after collisions", lines, 2);

    // R10: out-of-range select writes nothing
    cur_req = "R10";
    set_psc(0, 1);
    set_psc(3, 7);
    load(0, 2);
    measure(0, 0, lines);
    check(lines == 4, "R10", "ch0 unaffected by sel 3", lines, 4);

    // R9: idle strobes never wrap the count
    cur_req = "R9";
    for (int k = 0; k < 30; k++) step(1'b1);
    check(paused == 3'b000, "R9", "idle stays clear", paused, 0);

    // long prescale: N=255, M=2 -> 512 lines
    cur_req = "R3";
    set_psc(2, 255);
    load(2, 2);
    measure(2, 0, lines);
    check(lines == 512, "R3", "N=255 M=2 length", lines, 512);

    // mixed traffic against the model
    cur_req = "R7";
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h1) begin
        psc_we = 1'b1; psc_sel = lfsr[5:4]; psc_val = {5'd0, lfsr[8:6]};
      end
      if (lfsr[7:4] == 4'h2) begin
        pause_ld = lfsr[10:8]; pause_val = {8'd0, lfsr[14:11]};
      end
      chan_en = lfsr[13:11];
      step(lfsr[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule